// File: doc/BRIEF.md
# Inline ECC Address Mapper

This block sits between a system interconnect and a memory controller in a memory subsystem where the error-correction check bytes live in the same memory as the data. Physical memory is split into 576-byte strides: 512 bytes of data, then the 64 check bytes that cover them. One 8-bit SECDED check byte covers each 64-bit data word. The system sees an unbroken range of byte addresses, and the block spreads that range over the data part of each stride. About one ninth of physical space is left for check bytes. This layout is used everywhere in memory, whether checking is switched on for a given address or not.

The block also reports whether an address lies inside one of three programmable protected regions. Each region has an inclusive lower bound and an inclusive upper bound. Both bounds are offsets from the memory base, held at 64 KB granularity, meaning bits [31:16] of the offset. Software writes the bounds and the enable bits through a simple register write port. Each translation request gives, one clock later, the physical data address, the physical address of the check byte for that word, and a region-hit flag.

Top module: `iecc_addr_map`

## Requirements
- R1: For a system address A at or above the memory base (default 0x8000_0000), let O = A - base, taken modulo 2^32. The physical data address is (O / 512) * 576 + (O mod 512).
- R2: The physical check-byte address is (O / 512) * 576 + 512 + ((O mod 512) / 8). Each group of eight data bytes shares one check-byte address.
- R3: Data bytes within a block are contiguous. O = 511 maps to 511, and O = 512 maps to 576, which skips the 64 check bytes.
- R4: Region r matches when start_r <= O[31:16] <= end_r. Both bounds are inclusive.
- R5: While the global enable (control bit 0) is 0, the hit flag is 0 for every address and every region setting.
- R6: Region r takes part in the hit only while control bit r+1 is 1. The hit flag is the OR over the enabled regions.
- R7: A system address below the memory base never produces a hit, even when its wrapped offset falls inside a region.
- R8: Results appear on the outputs one clock after the request, with out_valid high for exactly that cycle. While in_valid is low, out_data_addr, out_chk_addr and out_hit keep their last values.
- R9: Synchronous active-high reset clears all outputs, the control register and every bound register to 0.
- R10: The register write index has this layout: 0 is control, 1+2r is the start bound of region r, and 2+2r is the end bound of region r. Bounds take wdata[15:0] and control takes wdata[3:0]. A write takes effect on the next request. Writes to indices 7 to 15 are ignored.
- R11: Translation does not depend on any enable bit. The interleaved layout applies while checking is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Translation request valid |
| in_addr | input | 32 | System byte address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data_addr | output | 33 | Physical data address |
| out_chk_addr | output | 33 | Physical check-byte address |
| out_hit | output | 1 | Address lies in an enabled protected region |

## Verification
The assertions check four things on every cycle:
- A data address always lands in the first 512 bytes of its 576-byte stride.
- Every check address is the one derived from its data address.
- The one-cycle valid timing and the holding of outputs between requests both follow R8.
- The hit flag stays low after the global enable was clear or the address was below the base.

Only the bench scenarios can show the rest:
- Inclusive bound edges.
- The per-region enable bits.
- The wrapped-offset case below the base.
- Ignored register indices.
- The exact arithmetic of the mapping, checked against a behavioural model on every clock.

// File: rtl/iecc_pkg.sv
package iecc_pkg;
  // Register write index layout (behavioural: software depends on it)
  localparam int CFG_IW       = 4;
  localparam int CFG_DW       = 32;
  localparam int CTRL_IDX     = 0;
  localparam int GLOBAL_BIT   = 0;

  function automatic int lo_bound_idx(input int r);
    return 1 + 2 * r;
  endfunction

  function automatic int hi_bound_idx(input int r);
    return 2 + 2 * r;
  endfunction
endpackage

// File: rtl/iecc_cfg_regs.sv
module iecc_cfg_regs
  import iecc_pkg::*;
#(
  parameter int NUM_REG = 3,
  parameter int BND_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [CFG_IW-1:0]               cfg_idx,
  input  logic [CFG_DW-1:0]               cfg_wdata,
  output logic                            glob_en,
  output logic [NUM_REG-1:0]              reg_en,
  output logic [NUM_REG-1:0][BND_W-1:0]   lo_bnd,
  output logic [NUM_REG-1:0][BND_W-1:0]   hi_bnd
);
  localparam logic [CFG_IW-1:0] CTRL_SEL = CFG_IW'(CTRL_IDX);

  logic [NUM_REG:0] ctrl_q;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (cfg_we && cfg_idx == CTRL_SEL) begin
      ctrl_q <= cfg_wdata[NUM_REG:0];
    end
  end

  assign glob_en = ctrl_q[GLOBAL_BIT];
  assign reg_en  = ctrl_q[NUM_REG:1];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_bnd
    localparam logic [CFG_IW-1:0] LO_SEL = CFG_IW'(lo_bound_idx(r));
    localparam logic [CFG_IW-1:0] HI_SEL = CFG_IW'(hi_bound_idx(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_bnd[r] <= '0;
        hi_bnd[r] <= '0;
      end else if (cfg_we) begin
        if (cfg_idx == LO_SEL) lo_bnd[r] <= cfg_wdata[BND_W-1:0];
        if (cfg_idx == HI_SEL) hi_bnd[r] <= cfg_wdata[BND_W-1:0];
      end
    end
  end
endmodule

// File: rtl/iecc_addr_xlate.sv
module iecc_addr_xlate #(
  parameter int SYS_AW     = 32,
  parameter int BLK_SHIFT  = 9,
  parameter int WORD_SHIFT = 3
) (
  input  logic [SYS_AW-1:0] offset,
  output logic [SYS_AW:0]   data_addr,
  output logic [SYS_AW:0]   chk_addr
);
  localparam int PHYS_AW   = SYS_AW + 1;
  localparam int CHK_SHIFT = BLK_SHIFT - WORD_SHIFT;
  localparam int BLK_BYTES = 1 << BLK_SHIFT;

  logic [PHYS_AW-1:0] blk_num;
  logic [PHYS_AW-1:0] stride_base;

  // stride = data block + check area = (1<<BLK_SHIFT) + (1<<CHK_SHIFT)
  assign blk_num     = PHYS_AW'(offset[SYS_AW-1:BLK_SHIFT]);
  assign stride_base = (blk_num << BLK_SHIFT) + (blk_num << CHK_SHIFT);
  assign data_addr   = stride_base + PHYS_AW'(offset[BLK_SHIFT-1:0]);
  assign chk_addr    = stride_base + PHYS_AW'(BLK_BYTES)
                     + PHYS_AW'(offset[BLK_SHIFT-1:WORD_SHIFT]);
endmodule

// File: rtl/iecc_region_match.sv
module iecc_region_match #(
  parameter int SYS_AW     = 32,
  parameter int GRAN_SHIFT = 16,
  parameter int NUM_REG    = 3
) (
  input  logic [SYS_AW-1:0]                         offset,
  input  logic                                      below_base,
  input  logic                                      glob_en,
  input  logic [NUM_REG-1:0]                        reg_en,
  input  logic [NUM_REG-1:0][SYS_AW-GRAN_SHIFT-1:0] lo_bnd,
  input  logic [NUM_REG-1:0][SYS_AW-GRAN_SHIFT-1:0] hi_bnd,
  output logic                                      hit
);
  localparam int BND_W = SYS_AW - GRAN_SHIFT;

  logic [BND_W-1:0]   seg;
  logic [NUM_REG-1:0] in_rng;
  logic               unused_low;

  assign seg        = offset[SYS_AW-1:GRAN_SHIFT];
  assign unused_low = ^offset[GRAN_SHIFT-1:0];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
    assign in_rng[r] = reg_en[r] && (seg >= lo_bnd[r]) && (seg <= hi_bnd[r]);
  end

  assign hit = glob_en && !below_base && (|in_rng);
endmodule

// File: rtl/iecc_addr_map.sv
module iecc_addr_map
  import iecc_pkg::*;
#(
  parameter int               SYS_AW     = 32,
  parameter logic [SYS_AW-1:0] MEM_BASE  = 'h8000_0000,
  parameter int               BLK_SHIFT  = 9,
  parameter int               WORD_SHIFT = 3,
  parameter int               GRAN_SHIFT = 16,
  parameter int               NUM_REG    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [SYS_AW-1:0] in_addr,
  output logic              out_valid,
  output logic [SYS_AW:0]   out_data_addr,
  output logic [SYS_AW:0]   out_chk_addr,
  output logic              out_hit
);
  localparam int PHYS_AW = SYS_AW + 1;
  localparam int BND_W   = SYS_AW - GRAN_SHIFT;

  logic                            glob_en;
  logic [NUM_REG-1:0]              reg_en;
  logic [NUM_REG-1:0][BND_W-1:0]   lo_bnd;
  logic [NUM_REG-1:0][BND_W-1:0]   hi_bnd;
  logic [SYS_AW-1:0]               offset;
  logic                            below_base;
  logic [PHYS_AW-1:0]              data_nx;
  logic [PHYS_AW-1:0]              chk_nx;
  logic                            hit_nx;

  assign offset     = in_addr - MEM_BASE;
  assign below_base = in_addr < MEM_BASE;

  iecc_cfg_regs #(.NUM_REG(NUM_REG), .BND_W(BND_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .glob_en  (glob_en),
    .reg_en   (reg_en),
    .lo_bnd   (lo_bnd),
    .hi_bnd   (hi_bnd)
  );

  iecc_addr_xlate #(
    .SYS_AW(SYS_AW), .BLK_SHIFT(BLK_SHIFT), .WORD_SHIFT(WORD_SHIFT)
  ) u_xlate (
    .offset   (offset),
    .data_addr(data_nx),
    .chk_addr (chk_nx)
  );

  iecc_region_match #(
    .SYS_AW(SYS_AW), .GRAN_SHIFT(GRAN_SHIFT), .NUM_REG(NUM_REG)
  ) u_match (
    .offset    (offset),
    .below_base(below_base),
    .glob_en   (glob_en),
    .reg_en    (reg_en),
    .lo_bnd    (lo_bnd),
    .hi_bnd    (hi_bnd),
    .hit       (hit_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_data_addr <= '0;
      out_chk_addr  <= '0;
      out_hit       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data_addr <= data_nx;
        out_chk_addr  <= chk_nx;
        out_hit       <= hit_nx;
      end
    end
  end
endmodule

// File: rtl/iecc_addr_map_chk.sv
module iecc_addr_map_chk #(
  parameter int               SYS_AW     = 32,
  parameter logic [SYS_AW-1:0] MEM_BASE  = 'h8000_0000,
  parameter int               BLK_SHIFT  = 9,
  parameter int               WORD_SHIFT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SYS_AW-1:0] in_addr,
  input logic              out_valid,
  input logic [SYS_AW:0]   out_data_addr,
  input logic [SYS_AW:0]   out_chk_addr,
  input logic              out_hit,
  input logic              glob_en
);
  localparam int PHYS_AW = SYS_AW + 1;
  localparam int BLK     = 1 << BLK_SHIFT;
  localparam int STRIDE  = BLK + (1 << (BLK_SHIFT - WORD_SHIFT));

  logic [PHYS_AW-1:0] d_mod;
  logic [PHYS_AW-1:0] chk_from_data;

  assign d_mod         = out_data_addr % PHYS_AW'(STRIDE);
  assign chk_from_data = out_data_addr - d_mod + PHYS_AW'(BLK) + (d_mod >> WORD_SHIFT);

  p_reset_quiet_r9: assert property (@(posedge clk) rst |=> !out_valid && !out_hit);

  p_data_in_block_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> d_mod < PHYS_AW'(BLK));

  p_chk_follows_data_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_chk_addr == chk_from_data);

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data_addr) && $stable(out_chk_addr) && $stable(out_hit));

  p_global_gate_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !glob_en |=> !out_hit);

  p_below_base_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_addr < MEM_BASE |=> !out_hit);
endmodule

bind iecc_addr_map iecc_addr_map_chk #(
  .SYS_AW(SYS_AW), .MEM_BASE(MEM_BASE), .BLK_SHIFT(BLK_SHIFT), .WORD_SHIFT(WORD_SHIFT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_addr      (in_addr),
  .out_valid    (out_valid),
  .out_data_addr(out_data_addr),
  .out_chk_addr (out_chk_addr),
  .out_hit      (out_hit),
  .glob_en      (glob_en)
);

// File: tb/iecc_addr_map_tb.sv
module iecc_addr_map_tb;
  localparam longint BASE = 64'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic [32:0] out_data_addr;
  logic [32:0] out_chk_addr;
  logic        out_hit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  iecc_addr_map u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_data_addr(out_data_addr), .out_chk_addr(out_chk_addr), .out_hit(out_hit)
  );

  // behavioural reference model
  longint m_ctrl;
  longint m_lo[3];
  longint m_hi[3];
  longint e_data, e_chk;
  bit     e_valid, e_hit;

  function automatic bit model_hit(longint a);
    longint off = (a - BASE) & 64'hFFFF_FFFF;
    longint seg = off >> 16;
    bit h = 0;
    if (a < BASE || m_ctrl[0] == 0) return 0;
    for (int r = 0; r < 3; r++)
      if (m_ctrl[r+1] && m_lo[r] <= seg && seg <= m_hi[r]) h = 1;
    return h;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; e_valid = 0; e_data = 0; e_chk = 0; e_hit = 0;
      for (int r = 0; r < 3; r++) begin m_lo[r] = 0; m_hi[r] = 0; end
    end else begin
      longint off;
      e_valid = in_valid;
      if (in_valid) begin
        off    = (longint'(in_addr) - BASE) & 64'hFFFF_FFFF;
        e_data = (off / 512) * 576 + (off % 512);
        e_chk  = (off / 512) * 576 + 512 + (off % 512) / 8;
        e_hit  = model_hit(longint'(in_addr));
      end
      if (cfg_we) begin
        if (cfg_idx == 0) m_ctrl = cfg_wdata & 32'hF;
        for (int r = 0; r < 3; r++) begin
          if (cfg_idx == 1 + 2*r) m_lo[r] = cfg_wdata & 32'hFFFF;
          if (cfg_idx == 2 + 2*r) m_hi[r] = cfg_wdata & 32'hFFFF;
        end
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == e_valid, "R8 valid", out_valid, e_valid);
      check(out_data_addr == e_data[32:0], "R1 data", out_data_addr, e_data);
      check(out_chk_addr == e_chk[32:0], "R2 chk", out_chk_addr, e_chk);
      check(out_hit == e_hit, "R4 hit", out_hit, e_hit);
    end
  end

  task automatic wr(int idx, longint d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[3:0]; cfg_wdata = d[31:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xl(longint a);
    @(negedge clk);
    in_valid = 1; in_addr = a[31:0];
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data_addr == 0 && out_chk_addr == 0 && out_hit == 0,
          "R9 reset outputs", {out_valid, out_hit}, 0);
    rst = 0;

    // R3/R11 layout with all enables off
    xl(BASE + 0);
    check(out_data_addr == 0 && out_chk_addr == 512, "R2 first word", out_chk_addr, 512);
    xl(BASE + 511);
    check(out_data_addr == 511, "R3 last byte of block", out_data_addr, 511);
    check(out_chk_addr == 575, "R2 last check byte", out_chk_addr, 575);
    xl(BASE + 512);
    check(out_data_addr == 576, "R3 skip check area", out_data_addr, 576);
    check(out_data_addr == 576 && out_hit == 0, "R11 interleave while disabled", out_data_addr, 576);
    xl(BASE + 64'h2000_0000);
    check(out_data_addr == 33'h2400_0000, "R1 large offset", out_data_addr, 33'h2400_0000);
    check(out_chk_addr == 33'h2400_0200, "R2 large offset", out_chk_addr, 33'h2400_0200);

    // region 0 over offsets 0x2000_0000..0x2BFF_FFFF, after a reset of the registers
    wr(1, 32'h2000); wr(2, 32'h2BFF);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 0, "R5 no hit with global off", out_hit, 0);
    wr(0, 32'h3);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 1, "R4 start inclusive", out_hit, 1);
    xl(BASE + 64'h2BFF_FFFF);
    check(out_hit == 1, "R4 end inclusive", out_hit, 1);
    xl(BASE + 64'h2C00_0000);
    check(out_hit == 0, "R4 past end", out_hit, 0);
    xl(BASE + 64'h1FFF_FFFF);
    check(out_hit == 0, "R4 before start", out_hit, 0);

    // region 1 programmed but not enabled
    wr(3, 32'h0100); wr(4, 32'h0100);
    xl(BASE + 64'h0100_8000);
    check(out_hit == 0, "R6 region disabled", out_hit, 0);
    wr(0, 32'h5);
    xl(BASE + 64'h0100_8000);
    check(out_hit == 1, "R6 region enabled", out_hit, 1);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 0, "R6 region0 bit cleared", out_hit, 0);

    // R7: wrapped offset would land in region 2
    wr(5, 32'hFFF0); wr(6, 32'hFFFF); wr(0, 32'hF);
    xl(64'h7FFF_0000);
    check(out_hit == 0, "R7 below base", out_hit, 0);
    xl(BASE - 64'h1_0000 + 64'h1_0000 + 64'h7FF8_0000);
    check(out_hit == 0, "R7 top offsets outside region2", out_hit, 0);

    // R5: global off again
    wr(0, 32'hE);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 0, "R5 global clear masks regions", out_hit, 0);
    wr(0, 32'hF);

    // R10: writes beyond index 6 ignored
    for (int i = 7; i < 16; i++) wr(i, 32'h0000_0000);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 1, "R10 ignored indices", out_hit, 1);
    wr(1, 32'hFFFF_2001);
    xl(BASE + 64'h2000_0000);
    check(out_hit == 0, "R10 bound uses low 16 bits", out_hit, 0);

    // R8: outputs hold while idle even with address moving
    @(negedge clk);
    in_addr = 32'h1234_5678;
    repeat (2) @(negedge clk);
    check(out_valid == 0 && out_data_addr == 33'h2400_0000, "R8 hold while idle",
          out_data_addr, 33'h2400_0000);

    // back-to-back sweep across a block boundary
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid = 1; in_addr = 32'(BASE + 64'h3000_01F0 + k * 3);
    end
    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule